// File: doc/BRIEF.md
# Two-Point ADC Linear Corrector

This block removes gain and offset error from the codes of an N-bit converter (N is 10 or 12). A calibration run is started with a one-cycle strobe. The block then takes one raw reading made with the reference input at one quarter of full scale and one made at three quarters. From the difference between the two readings it works out a gain, held as an integer number of millionths. It also works out a signed integer offset. These become the new correction coefficients only when both have been computed.

Between calibrations, and during them, every valid raw sample on the input stream is corrected with the coefficients in force. The result is clamped into the converter's code range and appears one clock later. If the high reading is not strictly above the low one, the run is rejected and the old coefficients stay in use. Selecting the reference source and waiting for it to settle are left to the surrounding logic.

Top module: `twopt_cal`

## Requirements
- R1: After reset the gain is 1,000,000 millionths and the offset is 0, so any in-range code leaves the block unchanged; `done`, `err` and `out_valid` are 0.
- R2: Only bits N-1..0 of `in_data` take part in the correction; higher bits have no effect on `out_data`.
- R3: `out_valid` equals `in_valid` one clock later. `out_data` is then trunc(raw * gain / 1,000,000) + offset, computed with the coefficients held when the sample was taken.
- R4: A corrected value below 0 is output as 0, and a value above 2^N - 1 is output as 2^N - 1.
- R5: On success the gain is trunc((2^(N-1)) * 1,000,000 / (hi - lo)). The offset is 2^(N-2) - trunc(lo * gain / 1,000,000). Here lo and hi are the quarter-scale and three-quarter-scale readings.
- R6: If hi <= lo, `err` is set, `done` stays 0 and both coefficients keep their previous values.
- R7: The new coefficients take effect on the same edge on which `done` rises. Samples taken before that edge use the old pair, and neither coefficient changes alone.
- R8: `cal_start` clears `done` and `err` on the next edge and restarts collection, discarding readings already captured. Within a run only the first valid reading of each reference is kept, and later ones are ignored.
- R9: The calibration readings are also reduced to their low N bits before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | One-cycle strobe that begins a calibration run |
| ref_lo_valid | input | 1 | `ref_lo` carries the quarter-scale reading this cycle |
| ref_lo | input | RAW_W | Raw reading at quarter scale |
| ref_hi_valid | input | 1 | `ref_hi` carries the three-quarter-scale reading this cycle |
| ref_hi | input | RAW_W | Raw reading at three-quarter scale |
| in_valid | input | 1 | Raw sample present |
| in_data | input | RAW_W | Raw sample |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | N | Corrected, clamped sample |
| done | output | 1 | Last calibration run succeeded and its coefficients are in use |
| err | output | 1 | Last calibration run was rejected |

## Verification
The bench attacks the clamp at both ends with a steep calibration, where large negative offsets push low codes below zero and high codes far past full scale. A design with a missing or sign-blind clamp would wrap these values instead of pinning them. It rejects runs with equal and with reversed readings; a design that committed early or divided by zero would change later outputs. It streams samples throughout each calibration so that any edge-early or partial coefficient switch shows up as a mismatch. It also feeds repeated references and codes with upper bits set, so that a design that overwrote the first reading or skipped the mask would compute a different gain.

// File: rtl/twopt_cal.sv
module twopt_cal #(
  parameter int N     = 12,
  parameter int RAW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic             ref_lo_valid,
  input  logic [RAW_W-1:0] ref_lo,
  input  logic             ref_hi_valid,
  input  logic [RAW_W-1:0] ref_hi,
  input  logic             in_valid,
  input  logic [RAW_W-1:0] in_data,
  output logic             out_valid,
  output logic [N-1:0]     out_data,
  output logic             done,
  output logic             err
);
  localparam int SW   = N + 20;
  localparam int PW   = N + SW;
  localparam int CW   = $clog2(PW + 1);
  localparam int MAXC = (1 << N) - 1;
  localparam int NOM0 = 1 << (N - 2);
  localparam int SPAN = 1 << (N - 1);
  localparam logic [PW-1:0] UNIT_W = PW'(1000000);
  localparam logic [PW-1:0] NUMER  = PW'(SPAN) * UNIT_W;

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_DSC, S_DBI} st_t;

  st_t               state;
  logic [N-1:0]      lo_q, hi_q;
  logic              got_lo, got_hi;
  logic [SW-1:0]     scale_q, scale_tmp;
  logic signed [SW:0] bias_q;
  logic [PW-1:0]     rem_q, quo_q, dvs_q;
  logic [CW-1:0]     cnt_q;

  logic [PW:0] shf, sub;
  logic        ge;
  assign shf = {rem_q, quo_q[PW-1]};
  assign sub = shf - {1'b0, dvs_q};
  assign ge  = shf >= {1'b0, dvs_q};

  logic [N-1:0]         raw_m;
  logic [PW-1:0]        prod, quot;
  logic signed [PW+1:0] sum_s;
  logic [N-1:0]         sat;
  assign raw_m = in_data[N-1:0];
  assign prod  = PW'(raw_m) * PW'(scale_q);
  assign quot  = prod / UNIT_W;
  assign sum_s = $signed({2'b00, quot}) + (PW+2)'(bias_q);
  assign sat   = (sum_s < 0) ? '0 :
                 (sum_s > $signed((PW+2)'(MAXC))) ? N'(MAXC) : sum_s[N-1:0];

  logic unused_ok;
  assign unused_ok = ^{in_data[RAW_W-1:N], ref_lo[RAW_W-1:N], ref_hi[RAW_W-1:N], sub[PW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      got_lo    <= 1'b0;
      got_hi    <= 1'b0;
      scale_q   <= SW'(1000000);
      scale_tmp <= '0;
      bias_q    <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      cnt_q     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else if (cal_start) begin
      state  <= S_COLL;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      case (state)
        S_COLL: begin
          if (ref_lo_valid && !got_lo) begin
            lo_q   <= ref_lo[N-1:0];
            got_lo <= 1'b1;
          end
          if (ref_hi_valid && !got_hi) begin
            hi_q   <= ref_hi[N-1:0];
            got_hi <= 1'b1;
          end
          if (got_lo && got_hi) begin
            if (hi_q <= lo_q) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              rem_q <= '0;
              quo_q <= NUMER;
              dvs_q <= PW'(hi_q - lo_q);
              cnt_q <= CW'(PW);
              state <= S_DSC;
            end
          end
        end
        S_DSC, S_DBI: begin
          if (cnt_q != 0) begin
            rem_q <= ge ? sub[PW-1:0] : shf[PW-1:0];
            quo_q <= {quo_q[PW-2:0], ge};
            cnt_q <= cnt_q - 1'b1;
          end else if (state == S_DSC) begin
            scale_tmp <= quo_q[SW-1:0];
            rem_q     <= '0;
            quo_q     <= PW'(lo_q) * PW'(quo_q[SW-1:0]);
            dvs_q     <= UNIT_W;
            cnt_q     <= CW'(PW);
            state     <= S_DBI;
          end else begin
            scale_q <= scale_tmp;
            bias_q  <= $signed((SW+1)'(NOM0)) - $signed({1'b0, quo_q[SW-1:0]});
            done    <= 1'b1;
            state   <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twopt_cal_chk.sv
module twopt_cal_chk #(
  parameter int N     = 12,
  parameter int RAW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_start,
  input logic              in_valid,
  input logic [RAW_W-1:0]  in_data,
  input logic              out_valid,
  input logic [N-1:0]      out_data,
  input logic              done,
  input logic              err,
  input logic [N+19:0]     scale_q,
  input logic signed [N+20:0] bias_q
);
  localparam logic [N+19:0] UNITY = (N+20)'(1000000);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R6
  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R3
  AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_q == UNITY && bias_q == 0 && in_valid) |=> (out_data == $past(in_data[N-1:0]))); // R1
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($stable(scale_q) && $stable(bias_q))); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (!done && !err)); // R8
endmodule

bind twopt_cal twopt_cal_chk #(.N(N), .RAW_W(RAW_W)) u_chk (.*);

// File: tb/tb_twopt_cal.sv
module tb_twopt_cal;
  localparam int N = 12, RAW_W = 16;
  localparam int CLK_P = 10;
  localparam longint MAXC = (64'd1 << N) - 1;

  logic clk = 0, rst_n = 0;
  logic cal_start = 0, ref_lo_valid = 0, ref_hi_valid = 0, in_valid = 0;
  logic [RAW_W-1:0] ref_lo = 0, ref_hi = 0, in_data = 0;
  logic out_valid, done, err;
  logic [N-1:0] out_data;

  twopt_cal #(.N(N), .RAW_W(RAW_W)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0;
  longint m_scale = 1000000, m_bias = 0, p_scale = 1000000, p_bias = 0;
  bit exp_v = 0, prev_done = 0, mon_on = 0;
  longint exp_d = 0;

  function automatic longint model(longint raw);
    longint v;
    v = (raw * m_scale) / 1000000 + m_bias;
    if (v < 0) v = 0;
    if (v > MAXC) v = MAXC;
    return v;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    check(out_valid == exp_v, "R3 out_valid", out_valid, exp_v);
    if (exp_v) check(out_data == exp_d, "R3/R4/R7 out_data", out_data, exp_d);
    if (done && !prev_done) begin m_scale = p_scale; m_bias = p_bias; end
    prev_done = done;
    exp_v = in_valid;
    exp_d = model(longint'(in_data[N-1:0]));
  end

  task automatic send_chk(input logic [RAW_W-1:0] d, input longint expv, input string req);
    @(posedge clk); #1 in_valid = 1; in_data = d;
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    check(out_data == expv[N-1:0], req, out_data, expv);
  endtask

  task automatic calibrate(input logic [RAW_W-1:0] lo, input logic [RAW_W-1:0] hi,
                           input bit dup, input bit ok);
    longint l, h;
    l = longint'(lo[N-1:0]); h = longint'(hi[N-1:0]);
    if (ok) begin
      p_scale = ((longint'(1) << (N-1)) * 1000000) / (h - l);
      p_bias  = (longint'(1) << (N-2)) - (l * p_scale) / 1000000;
    end
    @(posedge clk); #1 cal_start = 1;
    @(posedge clk); #1 cal_start = 0; ref_lo_valid = 1; ref_lo = lo;
    @(negedge clk); check(!done && !err, "R8 start clears flags", {done, err}, 0);
    @(posedge clk); #1 ref_lo_valid = dup; ref_lo = lo ^ 16'h0155; ref_hi_valid = 1; ref_hi = hi;
    @(posedge clk); #1 ref_lo_valid = 0; ref_hi_valid = 1; ref_hi = lo;
    @(posedge clk); #1 ref_hi_valid = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1 in_valid = 1; in_data = RAW_W'(i * 97 + 5);
      @(negedge clk);
      if (done || err) break;
    end
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    check(done == ok, "R5/R7 done", done, ok);
    check(err == !ok, "R6 err", err, !ok);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!out_valid && !done && !err, "R1 reset outputs", {out_valid, done, err}, 0);
    mon_on = 1;
    send_chk(16'h0123, 16'h123, "R1 pass-through");
    send_chk(16'h0FFF, 16'hFFF, "R1 pass-through top");
    send_chk(16'hF456, 16'h456, "R2 upper bits masked");
    // ideal references: gain stays 1e6, offset 0; R9 masked readings, R8 duplicate lo ignored
    calibrate(16'hA400, 16'h5C00, 1, 1);
    send_chk(16'h0777, 16'h777, "R5 ideal calibration identity");
    // offset and gain error
    calibrate(16'd1000, 16'd3100, 0, 1);
    send_chk(16'd2000, model(2000), "R5 corrected mid code");
    send_chk(16'd0, model(0), "R5 corrected zero");
    // rejections keep coefficients
    calibrate(16'd2000, 16'd2000, 0, 0);
    send_chk(16'd2000, model(2000), "R6 equal readings keep coefficients");
    calibrate(16'd3000, 16'd1000, 0, 0);
    send_chk(16'd1500, model(1500), "R6 reversed readings keep coefficients");
    // steep gain drives both clamps
    calibrate(16'd3000, 16'd3100, 0, 1);
    send_chk(16'd0, 0, "R4 clamp low");
    send_chk(16'd4095, MAXC, "R4 clamp high");
    send_chk(16'hFFFF, MAXC, "R4/R2 clamp high masked");
    send_chk(16'd3050, model(3050), "R4 inside range");
    // restart discards a lone captured reading
    @(posedge clk); #1 cal_start = 1;
    @(posedge clk); #1 cal_start = 0; ref_lo_valid = 1; ref_lo = 16'd50;
    @(posedge clk); #1 ref_lo_valid = 0;
    calibrate(16'd1024, 16'd3072, 0, 1);
    send_chk(16'd1234, 16'd1234, "R8 restart then ideal calibration");
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule